// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix-Multiply Array

This block is a two-dimensional grid of signed multiply-accumulate cells that computes one vector-times-matrix product per cycle once its pipeline is full. Before a computation, each cell is given one 8-bit weight: a whole grid row of weights is written per cycle through the weight port, and the weights then stay in place. Each grid column holds one filter and each grid row one input channel. During computation an activation vector (one value per row) enters each cycle and moves rightward along the rows. Alongside it comes a seed vector (one 32-bit value per column), normally the output previously stored in the result buffer. The seed travels down its column, each cell adding its weight times the activation passing through it. The updated column sums leave at the bottom and go back to the same buffer, so results accumulate across successive operations instead of starting from zero.

The caller presents activation and seed vectors unskewed. The block delays row r by r cycles and column c's seed by c cycles on entry. It delays column c's result by COLS-1-c cycles on exit, so a complete result vector appears together, ROWS+COLS-1 cycles after its inputs were accepted. A `start` pulse sets how many vectors the operation takes. `busy` covers the whole operation. A one-cycle `done` follows the final result. Weight writes are refused while an operation runs.

Top module: `sga_array`

## Requirements
- R1: After reset `busy`, `in_ready`, `out_valid` and `done` are all 0.
- R2: While `busy` is 0, `wload_en` writes the weight for row `wload_row`, column c from `wload_data[c*8 +: 8]` (signed 8-bit) for every column c; the write is used by every later operation.
- R3: A weight write attempted while `busy` is 1 has no effect: later results still use the previously loaded weights.
- R4: Each result satisfies `out_psum[c*32 +: 32]` = `in_psum[c*32 +: 32]` + sum over rows r of w(r,c) times `in_act[r*8 +: 8]` (all signed), taken modulo 2^32 with two's-complement wrap.
- R5: A vector accepted in a cycle (`in_valid` and `in_ready` both 1) produces exactly one result with `out_valid` high exactly ROWS+COLS-1 cycles later. Results come in acceptance order, and idle input cycles between vectors are allowed.
- R6: `in_ready` is 1 only while `busy` is 1 and fewer than `num_vec` vectors have been accepted in the current operation. `in_valid` while `in_ready` is 0 is ignored and yields no result.
- R7: `done` is a one-cycle pulse in the cycle after the final result's `out_valid`, and `busy` is 0 from that cycle. A `start` with `num_vec` = 0 gives `done` in the next cycle and no results.
- R8: `start` while `busy` is 1 is ignored: the running operation keeps its vector count and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wload_en | input | 1 | Write one grid row of weights |
| wload_row | input | RIW | Grid row addressed by the weight write |
| wload_data | input | COLS*DW | One signed weight per column |
| start | input | 1 | Begin an operation (idle only) |
| num_vec | input | CW | Number of vectors the operation takes |
| in_valid | input | 1 | Activation and seed vectors present |
| in_act | input | ROWS*DW | Signed activation per grid row |
| in_psum | input | COLS*AW | Seed partial sum per grid column |
| in_ready | output | 1 | A vector is accepted this cycle if valid |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | Result vector present |
| out_psum | output | COLS*AW | Updated column sums |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The hardest situations to reach are the ones where the control must refuse something in the middle of a stream. One is a weight write and a second `start` arriving while vectors are still inside the grid. Another is `in_valid` held high after the agreed count has been accepted. The bench drives these from a parallel process partway through a long batch. It then runs a fresh batch and compares the results against a weight model that only accepts writes while idle, so any leaked write shows up as wrong sums. Wrap-around is reached by loading all weights as -128 and seeding with the extreme 32-bit values. The 256-vector sweep places every 8-bit activation value on every row.

// File: rtl/sga_pkg.sv
package sga_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/sga_delay.sv
module sga_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_d [D];
    logic [W-1:0] pipe_q [D];

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < D; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[D-1];

endmodule

// File: rtl/sga_pe.sv
module sga_pe #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 w_we,
    input  logic [DW-1:0]        w_in,
    input  logic signed [DW-1:0] act_in,
    input  logic [AW-1:0]        psum_in,
    output logic [AW-1:0]        psum_out
);

    localparam int PW  = 2 * DW;
    localparam int EXT = AW - PW;

    typedef struct packed {
        logic [DW-1:0] w;
        logic [AW-1:0] psum;
    } pe_st_t;

    pe_st_t                st_d, st_q;
    logic signed [PW-1:0]  prod;

    always_comb begin
        st_d = st_q;
        if (w_we) begin
            st_d.w = w_in;
        end
        prod      = $signed(st_q.w) * act_in;
        st_d.psum = psum_in + {{EXT{prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign psum_out = st_q.psum;

endmodule

// File: rtl/sga_ctrl.sv
module sga_ctrl
    import sga_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] num_vec,
    input  logic          in_valid,
    input  logic          res_valid,
    output logic          accept,
    output logic          in_ready,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] fed;
        logic [CW-1:0] total;
        logic [CW-1:0] emitted;
        logic          done;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        in_ready  = (st_q.phase == PH_RUN) && (st_q.fed != st_q.total);
        accept    = in_ready && in_valid;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    if (num_vec == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase   = PH_RUN;
                        st_d.total   = num_vec;
                        st_d.fed     = '0;
                        st_d.emitted = '0;
                    end
                end
            end
            default: begin
                if (accept) begin
                    st_d.fed = st_q.fed + 1'b1;
                end
                if (res_valid) begin
                    if (st_q.emitted == st_q.total - 1'b1) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.emitted = st_q.emitted + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == PH_RUN);
    assign done = st_q.done;

endmodule

// File: rtl/sga_array.sv
module sga_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 8,
    parameter int AW   = 32,
    parameter int CW   = 16,
    localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wload_en,
    input  logic [RIW-1:0]       wload_row,
    input  logic [COLS*DW-1:0]   wload_data,
    input  logic                 start,
    input  logic [CW-1:0]        num_vec,
    input  logic                 in_valid,
    input  logic [ROWS*DW-1:0]   in_act,
    input  logic [COLS*AW-1:0]   in_psum,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 out_valid,
    output logic [COLS*AW-1:0]   out_psum,
    output logic                 done
);

    localparam int LAT = ROWS + COLS - 1;

    logic              accept;
    logic              res_valid;
    logic              w_open;
    logic [DW-1:0]     act_g  [ROWS][COLS];
    logic [AW-1:0]     top_g  [COLS];
    logic [AW-1:0]     psum_g [ROWS][COLS];

    sga_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .num_vec   (num_vec),
        .in_valid  (in_valid),
        .res_valid (res_valid),
        .accept    (accept),
        .in_ready  (in_ready),
        .busy      (busy),
        .done      (done)
    );

    sga_delay #(.W(1), .D(LAT)) u_vpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (accept),
        .dout  (res_valid)
    );

    assign out_valid = res_valid;
    assign w_open    = !busy;

    // Activation entry skew (row r waits r cycles) and rightward hops.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == 0) begin : g_noskew
            assign act_g[r][0] = in_act[r*DW +: DW];
        end else begin : g_skew
            sga_delay #(.W(DW), .D(r)) u_askew (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (in_act[r*DW +: DW]),
                .dout  (act_g[r][0])
            );
        end
        for (genvar c = 1; c < COLS; c++) begin : g_hop
            sga_delay #(.W(DW), .D(1)) u_ahop (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (act_g[r][c-1]),
                .dout  (act_g[r][c])
            );
        end
    end

    // Seed entry skew (column c waits c cycles) and exit deskew.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        if (c == 0) begin : g_noskew
            assign top_g[c] = in_psum[c*AW +: AW];
        end else begin : g_skew
            sga_delay #(.W(AW), .D(c)) u_pskew (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (in_psum[c*AW +: AW]),
                .dout  (top_g[c])
            );
        end
        if (c == COLS - 1) begin : g_nodeskew
            assign out_psum[c*AW +: AW] = psum_g[ROWS-1][c];
        end else begin : g_deskew
            sga_delay #(.W(AW), .D(COLS - 1 - c)) u_odeskew (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (psum_g[ROWS-1][c]),
                .dout  (out_psum[c*AW +: AW])
            );
        end
    end

    // Cell grid: weight stays put, sum flows down.
    for (genvar r = 0; r < ROWS; r++) begin : g_pr
        for (genvar c = 0; c < COLS; c++) begin : g_pc
            logic          we_rc;
            logic [AW-1:0] sum_in;
            assign we_rc = wload_en && w_open && (wload_row == RIW'(r));
            if (r == 0) begin : g_top
                assign sum_in = top_g[c];
            end else begin : g_mid
                assign sum_in = psum_g[r-1][c];
            end
            sga_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .w_we     (we_rc),
                .w_in     (wload_data[c*DW +: DW]),
                .act_in   ($signed(act_g[r][c])),
                .psum_in  (sum_in),
                .psum_out (psum_g[r][c])
            );
        end
    end

endmodule

// File: rtl/sga_checker.sv
module sga_checker #(
    parameter int CW = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic out_valid,
    input logic done
);

    logic [CW:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q + (CW+1)'(in_valid && in_ready) - (CW+1)'(out_valid);
        end
    end

    a_r6_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    a_r5_result_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_q != '0));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(busy)) |-> $past(out_valid));

    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !in_ready && !out_valid));

    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind sga_array sga_checker #(.CW(CW)) u_sga_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .done      (done)
);

// File: tb/test_sga_array.sv
module test_sga_array;

    localparam int NR  = 3;
    localparam int NC  = 4;
    localparam int DW  = 8;
    localparam int AW  = 32;
    localparam int CW  = 16;
    localparam int LAT = NR + NC - 1;
    localparam int RIW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic            wload_en = 1'b0;
    logic [RIW-1:0]  wload_row = '0;
    logic [NC*DW-1:0] wload_data = '0;
    logic            start = 1'b0;
    logic [CW-1:0]   num_vec = '0;
    logic            in_valid = 1'b0;
    logic [NR*DW-1:0] in_act = '0;
    logic [NC*AW-1:0] in_psum = '0;
    logic            in_ready, busy, out_valid, done;
    logic [NC*AW-1:0] out_psum;

    int checks = 0, errors = 0, cyc = 0;
    int wm [NR][NC];
    logic [NC*AW-1:0] expq [4096];
    int acyc [4096];
    int wr = 0, rd = 0;
    int last_out_cyc = 0, done_cyc = 0, start_cyc = 0, done_cnt = 0;

    always #5 clk = ~clk;

    sga_array #(.ROWS(NR), .COLS(NC), .DW(DW), .AW(AW), .CW(CW)) i_sga_array (
        .clk(clk), .rst_n(rst_n), .wload_en(wload_en), .wload_row(wload_row),
        .wload_data(wload_data), .start(start), .num_vec(num_vec),
        .in_valid(in_valid), .in_act(in_act), .in_psum(in_psum),
        .in_ready(in_ready), .busy(busy), .out_valid(out_valid),
        .out_psum(out_psum), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [NC*AW-1:0] act, input logic [NC*AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc++;

    // Bench-side model and result monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wload_en && !busy && int'(wload_row) < NR) begin
                for (int c = 0; c < NC; c++) begin
                    wm[wload_row][c] = int'($signed(wload_data[c*DW +: DW]));
                end
            end
            if (in_valid && in_ready) begin
                logic [NC*AW-1:0] e;
                for (int c = 0; c < NC; c++) begin
                    int s;
                    s = int'(in_psum[c*AW +: AW]);
                    for (int r = 0; r < NR; r++) begin
                        s += wm[r][c] * int'($signed(in_act[r*DW +: DW]));
                    end
                    e[c*AW +: AW] = s;
                end
                expq[wr] = e;
                acyc[wr] = cyc;
                wr++;
            end
            if (out_valid) begin
                if (rd < wr) begin
                    chk(out_psum == expq[rd], "R4 result sums", out_psum, expq[rd]);
                    chk(cyc - acyc[rd] == LAT, "R5 latency", cyc - acyc[rd], LAT);
                    rd++;
                end else begin
                    chk(1'b0, "R6 result without accepted vector", 1, 0);
                end
                last_out_cyc = cyc;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (start && !busy) start_cyc = cyc;
        end
    end

    task automatic load_row(input int r, input logic [NC*DW-1:0] d);
        @(posedge clk); #1;
        wload_en = 1'b1; wload_row = RIW'(r); wload_data = d;
        @(posedge clk); #1;
        wload_en = 1'b0;
    endtask

    task automatic drive_vec(input int k, input int mode);
        for (int r = 0; r < NR; r++) begin
            case (mode)
                0:       in_act[r*DW +: DW] = DW'(k + r * 85);
                1:       in_act[r*DW +: DW] = (k % 2 == 0) ? 8'h80 : 8'h7F;
                default: in_act[r*DW +: DW] = DW'(k * 29 + r * 11 + 5);
            endcase
        end
        for (int c = 0; c < NC; c++) begin
            case (mode)
                0:       in_psum[c*AW +: AW] = k * 32'h01030507 + c * 1000;
                1:       in_psum[c*AW +: AW] = (k % 2 == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
                default: in_psum[c*AW +: AW] = -k * 77 + c;
            endcase
        end
    endtask

    task automatic run_batch(input int n, input int mode, input int extra, input bit gaps);
        int k = 0;
        int xl = extra;
        int dc0 = done_cnt;
        int rd0 = rd;
        int t = 0;
        @(posedge clk); #1;
        start = 1'b1; num_vec = CW'(n);
        @(posedge clk); #1;
        start = 1'b0;
        while (k < n || xl > 0) begin
            if (k < n) begin
                in_valid = !(gaps && (cyc % 3 == 0));
                drive_vec(k, mode);
            end else begin
                in_valid = 1'b1;
                drive_vec(k, mode);
            end
            @(negedge clk);
            if (k >= n) begin
                chk(!in_ready, "R6 ready after count reached", in_ready, 0);
                xl--;
            end else if (in_valid && in_ready) begin
                k++;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        while (done_cnt == dc0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(done_cnt == dc0 + 1, "R7 one done per operation", done_cnt - dc0, 1);
        chk(rd - rd0 == n, "R5 one result per vector", rd - rd0, n);
        chk(rd == wr, "R5 no missing results", rd, wr);
        if (n > 0)
            chk(done_cyc == last_out_cyc + 1, "R7 done follows last result", done_cyc, last_out_cyc + 1);
        else
            chk(done_cyc == start_cyc + 1, "R7 empty operation done", done_cyc, start_cyc + 1);
        chk(!busy, "R7 busy low at done", busy, 0);
        repeat (3) @(negedge clk);
        chk(done_cnt == dc0 + 1, "R7 done single pulse", done_cnt - dc0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(!in_ready, "R1 in_ready after reset", in_ready, 0);
        chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
        chk(!done, "R1 done after reset", done, 0);

        // R2 weight load, R4/R5 sweep of every 8-bit activation on each row.
        for (int r = 0; r < NR; r++) begin
            logic [NC*DW-1:0] d;
            for (int c = 0; c < NC; c++) d[c*DW +: DW] = DW'((r * NC + c) * 23 - 100);
            load_row(r, d);
        end
        run_batch(256, 0, 0, 1'b0);

        // R4 extremes and 32-bit wrap.
        for (int r = 0; r < NR; r++) load_row(r, {NC{8'h80}});
        run_batch(6, 1, 0, 1'b0);

        // R5 with idle input cycles.
        for (int r = 0; r < NR; r++) begin
            logic [NC*DW-1:0] d;
            for (int c = 0; c < NC; c++) d[c*DW +: DW] = DW'(r - c * 3);
            load_row(r, d);
        end
        run_batch(20, 2, 0, 1'b1);

        // R3 weight write and R8 start while running.
        fork
            run_batch(30, 2, 0, 1'b0);
            begin
                repeat (8) @(posedge clk);
                #2;
                wload_en = 1'b1; wload_row = RIW'(1); wload_data = {NC{8'h11}};
                start = 1'b1; num_vec = CW'(5);
                @(posedge clk); #2;
                wload_en = 1'b0; start = 1'b0;
            end
        join
        run_batch(5, 0, 0, 1'b0);

        // R7 empty operation.
        run_batch(0, 2, 0, 1'b0);

        // R6 input while idle is ignored.
        @(posedge clk); #1;
        in_valid = 1'b1; drive_vec(3, 2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!in_ready, "R6 ready while idle", in_ready, 0);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (LAT + 3) @(negedge clk);
        chk(rd == wr, "R6 no result from idle input", rd, wr);

        // R6 valid held past the vector count.
        run_batch(3, 2, 4, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule